// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between a set of per-class ready queues and the execute stage of an out-of-order core. Every operation class offers only the head of its ready queue: a valid bit, a sequence number, a squashed flag and a memory flag. Each cycle the selector ranks the live heads by age, with the smallest sequence number first. It hands out up to `WIDTH` issue slots in that order and strobes `pop` back to each queue whose head it consumed.

Each class has one execution unit, and class 0 is a pseudo-class that needs no unit. The per-class latency inputs decide how a granted operation reaches the execute stage. A plain operation is delivered at once and leaves its unit free for the following cycle. A long operation has both latencies above one. It holds its unit and appears on that class's completion port `iss_lat - 1` cycles after it issued. A head whose unit is reserved is skipped and counted as a busy event, and it takes no slot. A squashed head is thrown away and takes no slot either. The class is ranked again on its next head in the following cycle.

Top module: `oldest_issue_select`

## Requirements
- R1: Granted heads fill slots in age order. Slot 0 gets the smallest sequence number and each later valid slot holds a sequence number no smaller than the one before it. Equal numbers go to the lower class index first. Valid slots are packed from slot 0.
- R2: At most `WIDTH` heads are granted per cycle. Once `WIDTH` eligible older heads exist, no younger head is granted.
- R3: A valid head with its squashed flag set is popped in that same cycle, whatever the issue width. It is never granted, it takes no slot and it does not assert `entry_rel`.
- R4: A valid, unsquashed head whose unit is reserved is not granted and not popped. The class's `busy_cnt` is incremented by one at the next edge, saturating at all ones, but only when fewer than `WIDTH` eligible heads are older than it.
- R5: Class 0 needs no unit. It issues with `slot_late` = 0 whatever its latency inputs are, and it can issue in consecutive cycles.
- R6: When a class has `op_lat` <= 1 or `iss_lat` <= 1, its grant is delivered at once with `slot_late` = 0, and the class can issue again in the next cycle.
- R7: When a class other than 0 has `op_lat` > 1 and `iss_lat` > 1, its grant has `slot_late` = 1 and the unit stays reserved. `done_vld` for that class is high exactly `iss_lat - 1` cycles after the issue cycle, with `done_seq` equal to the issued sequence number. The class can issue again in the cycle after that.
- R8: Every grant pops its head. `entry_rel` is asserted together with the pop only when `hd_mem` of that class is 0, so a memory operation keeps its queue entry.
- R9: `active` is high in exactly those cycles in which at least one slot is valid.
- R10: After reset no unit is reserved, every `busy_cnt` is zero and `done_vld` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hd_valid | input | NCLS | Class has a ready head |
| hd_seq | input | NCLS x SEQW | Sequence number of each head |
| hd_squash | input | NCLS | Head is squashed |
| hd_mem | input | NCLS | Head is a memory operation |
| op_lat | input | NCLS x LATW | Operation latency of each class |
| iss_lat | input | NCLS x LATW | Issue latency of each class |
| pop | output | NCLS | Remove the head of the class queue |
| entry_rel | output | NCLS | Release the queue entry of the popped head |
| slot_vld | output | WIDTH | Issue slot is filled |
| slot_cls | output | WIDTH x CLSW | Class that fills the slot |
| slot_seq | output | WIDTH x SEQW | Sequence number in the slot |
| slot_late | output | WIDTH | Slot is delivered later through the completion port |
| done_vld | output | NCLS | Reserved unit of the class completes this cycle |
| done_seq | output | NCLS x SEQW | Sequence number completing on the class |
| busy_cnt | output | NCLS x BCW | Busy-unit events per class |
| active | output | 1 | At least one slot issued this cycle |

## Verification
Several checks run on every cycle. Valid slots must be packed and in non-decreasing age order. The number of slots must match the number of non-squashed pops. A squashed head must always be dropped without releasing an entry, a release must always come from a non-memory pop, and `active` must agree with the slots. Every cycle also confirms that a reserved unit is never granted, that its timer loads from the issue latency, and that the busy counter steps. The bench scenarios alone can show the ranking itself on chosen sequence numbers: ties, squash mixes and the width cut-off. They also show the exact completion cycle and sequence number of a long operation, and that a busy head is counted only when it lies within the visited window.

// File: rtl/isel_pkg.sv
package isel_pkg;

    // How a granted head reaches the execute stage
    typedef enum logic [1:0] {
        DLV_NONE = 2'd0,
        DLV_NOW  = 2'd1,
        DLV_LATE = 2'd2
    } dlv_e;

endpackage

// File: rtl/isel_rank.sv
// Pairwise age comparison of all class heads: each class learns how many
// eligible heads are older than itself, which is also its slot index.
module isel_rank #(
    parameter int NCLS  = 4,
    parameter int SEQW  = 8,
    parameter int WIDTH = 2,
    localparam int CW   = $clog2(NCLS + 1)
) (
    input  logic [NCLS-1:0]           elig,
    input  logic [NCLS-1:0]           cand,
    input  logic [NCLS-1:0][SEQW-1:0] seq,
    output logic [NCLS-1:0][CW-1:0]   ahead,
    output logic [NCLS-1:0]           grant,
    output logic [NCLS-1:0]           visit
);

    logic [NCLS-1:0][NCLS-1:0] older;   // older[i][j]: eligible j is ahead of i

    for (genvar i = 0; i < NCLS; i++) begin : g_row
        for (genvar j = 0; j < NCLS; j++) begin : g_col
            if (j < i) begin : g_lo
                assign older[i][j] = elig[j] && (seq[j] <= seq[i]);
            end else if (j > i) begin : g_hi
                assign older[i][j] = elig[j] && (seq[j] < seq[i]);
            end else begin : g_self
                assign older[i][j] = 1'b0;
            end
        end
        assign ahead[i] = CW'($countones(older[i]));
        assign visit[i] = cand[i] && (int'(ahead[i]) < WIDTH);
        assign grant[i] = elig[i] && visit[i];
    end

endmodule

// File: rtl/isel_unit.sv
// One execution unit per class: reservation timer, completion report and
// busy-event counter.
module isel_unit #(
    parameter int SEQW = 8,
    parameter int LATW = 3,
    parameter int BCW  = 8,
    parameter bit NOFU = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            grant,
    input  logic            defer,
    input  logic [LATW-1:0] iss_lat,
    input  logic [SEQW-1:0] seq_in,
    input  logic            busy_hit,
    output logic            avail,
    output logic            done_vld,
    output logic [SEQW-1:0] done_seq,
    output logic [BCW-1:0]  busy_cnt
);

    typedef struct packed {
        logic            busy;
        logic [LATW-1:0] cnt;
        logic [SEQW-1:0] seq;
        logic [BCW-1:0]  bcnt;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic     defer_eff;

    assign defer_eff = defer && !NOFU;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == LATW'(1)) st_d.busy = 1'b0;
            else                      st_d.cnt  = st_q.cnt - LATW'(1);
        end
        if (grant && defer_eff) begin
            st_d.busy = 1'b1;
            st_d.cnt  = iss_lat - LATW'(1);
            st_d.seq  = seq_in;
        end
        if (busy_hit && (st_q.bcnt != '1)) begin
            st_d.bcnt = st_q.bcnt + BCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avail    = !st_q.busy;
    assign done_vld = st_q.busy && (st_q.cnt == LATW'(1));
    assign done_seq = st_q.seq;
    assign busy_cnt = st_q.bcnt;

    assert_no_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !grant);
    assert_timer_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && defer_eff) |=> (st_q.busy && st_q.cnt == $past(iss_lat) - LATW'(1)));
    assert_busy_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_hit && st_q.bcnt != '1) |=> (st_q.bcnt == $past(st_q.bcnt) + BCW'(1)));
    assert_quick_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !defer) |=> !st_q.busy);

endmodule

// File: rtl/oldest_issue_select.sv
module oldest_issue_select #(
    parameter int NCLS  = 4,
    parameter int WIDTH = 2,
    parameter int SEQW  = 8,
    parameter int LATW  = 3,
    parameter int BCW   = 8,
    localparam int CLSW = (NCLS > 1) ? $clog2(NCLS) : 1,
    localparam int CW   = $clog2(NCLS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCLS-1:0]            hd_valid,
    input  logic [NCLS-1:0][SEQW-1:0]  hd_seq,
    input  logic [NCLS-1:0]            hd_squash,
    input  logic [NCLS-1:0]            hd_mem,
    input  logic [NCLS-1:0][LATW-1:0]  op_lat,
    input  logic [NCLS-1:0][LATW-1:0]  iss_lat,
    output logic [NCLS-1:0]            pop,
    output logic [NCLS-1:0]            entry_rel,
    output logic [WIDTH-1:0]           slot_vld,
    output logic [WIDTH-1:0][CLSW-1:0] slot_cls,
    output logic [WIDTH-1:0][SEQW-1:0] slot_seq,
    output logic [WIDTH-1:0]           slot_late,
    output logic [NCLS-1:0]            done_vld,
    output logic [NCLS-1:0][SEQW-1:0]  done_seq,
    output logic [NCLS-1:0][BCW-1:0]   busy_cnt,
    output logic                       active
);
    import isel_pkg::*;

    logic [NCLS-1:0]         cand, elig, avail, grant, visit, busy_hit, drop, defer;
    logic [NCLS-1:0][CW-1:0] ahead;
    dlv_e                    route [NCLS];

    assign cand     = hd_valid & ~hd_squash;
    assign elig     = cand & avail;
    assign drop     = hd_valid & hd_squash;
    assign busy_hit = visit & ~elig;

    isel_rank #(.NCLS(NCLS), .SEQW(SEQW), .WIDTH(WIDTH)) u_rank (
        .elig  (elig),
        .cand  (cand),
        .seq   (hd_seq),
        .ahead (ahead),
        .grant (grant),
        .visit (visit)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign defer[c] = (c != 0) && (op_lat[c] > LATW'(1)) && (iss_lat[c] > LATW'(1));

        always_comb begin
            if (!grant[c])     route[c] = DLV_NONE;
            else if (defer[c]) route[c] = DLV_LATE;
            else               route[c] = DLV_NOW;
        end

        isel_unit #(.SEQW(SEQW), .LATW(LATW), .BCW(BCW), .NOFU(c == 0)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .grant    (grant[c]),
            .defer    (defer[c]),
            .iss_lat  (iss_lat[c]),
            .seq_in   (hd_seq[c]),
            .busy_hit (busy_hit[c]),
            .avail    (avail[c]),
            .done_vld (done_vld[c]),
            .done_seq (done_seq[c]),
            .busy_cnt (busy_cnt[c])
        );

        assign pop[c]       = drop[c] || (route[c] != DLV_NONE);
        assign entry_rel[c] = (route[c] != DLV_NONE) && !hd_mem[c];

        assert_squash_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
            drop[c] |-> (pop[c] && !entry_rel[c]));
        assert_mem_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            entry_rel[c] |-> (pop[c] && !hd_mem[c]));
    end

    // Slot multiplexer: a granted class lands in the slot named by its rank
    always_comb begin
        slot_vld  = '0;
        slot_cls  = '0;
        slot_seq  = '0;
        slot_late = '0;
        for (int s = 0; s < WIDTH; s++) begin
            for (int c = 0; c < NCLS; c++) begin
                if (grant[c] && (int'(ahead[c]) == s)) begin
                    slot_vld[s]  = 1'b1;
                    slot_cls[s]  = CLSW'(c);
                    slot_seq[s]  = hd_seq[c];
                    slot_late[s] = (route[c] == DLV_LATE);
                end
            end
        end
    end

    assign active = |grant;

    assert_slot_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_vld) == $countones(pop & ~drop));
    assert_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active == (slot_vld != '0));

    for (genvar s = 1; s < WIDTH; s++) begin : g_ord
        assert_age_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[s] |-> (slot_vld[s-1] && slot_seq[s-1] <= slot_seq[s]));
    end

endmodule

// File: tb/test_oldest_issue_select.sv
module test_oldest_issue_select;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       hd_valid = '0, hd_squash = '0, hd_mem = '0;
    logic [3:0][7:0]  hd_seq = '0;
    logic [3:0][2:0]  op_lat, iss_lat;
    logic [3:0]       pop, entry_rel, done_vld;
    logic [1:0]       slot_vld, slot_late;
    logic [1:0][1:0]  slot_cls;
    logic [1:0][7:0]  slot_seq;
    logic [3:0][7:0]  done_seq;
    logic [3:0][7:0]  busy_cnt;
    logic             active;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    oldest_issue_select i_oldest_issue_select (
        .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_seq(hd_seq),
        .hd_squash(hd_squash), .hd_mem(hd_mem), .op_lat(op_lat), .iss_lat(iss_lat),
        .pop(pop), .entry_rel(entry_rel), .slot_vld(slot_vld), .slot_cls(slot_cls),
        .slot_seq(slot_seq), .slot_late(slot_late), .done_vld(done_vld),
        .done_seq(done_seq), .busy_cnt(busy_cnt), .active(active)
    );

    typedef struct packed {
        logic [3:0]  v;
        logic [3:0]  sq;
        logic [3:0]  mem;
        logic [31:0] seq;
        logic [3:0]  pop;
        logic [3:0]  rel;
        logic        act;
        logic        s0v;
        logic [1:0]  s0c;
        logic        s1v;
        logic [1:0]  s1c;
    } vec_t;

    // Single-cycle cases, all latencies 1; seq packed {c3,c2,c1,c0}
    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{4'b1111, 4'b0000, 4'b0000, 32'h141E0A28, 4'b1010, 4'b1010, 1'b1, 1'b1, 2'd1, 1'b1, 2'd3},
        '{4'b0001, 4'b0000, 4'b0000, 32'h00000005, 4'b0001, 4'b0001, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0},
        '{4'b1111, 4'b0010, 4'b0000, 32'h141E0A28, 4'b1110, 4'b1100, 1'b1, 1'b1, 2'd3, 1'b1, 2'd2},
        '{4'b0000, 4'b0000, 4'b0000, 32'h141E0A28, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0},
        '{4'b1111, 4'b0000, 4'b1010, 32'h141E0A28, 4'b1010, 4'b0000, 1'b1, 1'b1, 2'd1, 1'b1, 2'd3},
        '{4'b0110, 4'b0000, 4'b0000, 32'h07070707, 4'b0110, 4'b0110, 1'b1, 1'b1, 2'd1, 1'b1, 2'd2},
        '{4'b0100, 4'b0100, 4'b0000, 32'h00000000, 4'b0100, 4'b0000, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0},
        '{4'b1111, 4'b0001, 4'b0000, 32'h04030201, 4'b0111, 4'b0110, 1'b1, 1'b1, 2'd1, 1'b1, 2'd2}
    };

    task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [3:0] sq, input logic [3:0] mm,
                         input logic [31:0] sqn);
        @(negedge clk);
        hd_valid = v; hd_squash = sq; hd_mem = mm; hd_seq = sqn;
        #3;
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin op_lat[c] = 3'd1; iss_lat[c] = 3'd1; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(4'b0000, 4'b0000, 4'b0000, 32'h0);
        chk(busy_cnt == '0, "R10 busy_cnt", int'(busy_cnt[0]), 0);
        chk(done_vld == '0, "R10 done_vld", int'(done_vld), 0);
        chk(pop == '0 && !active, "R10 idle", int'(pop), 0);

        // R1 R2 R3 R8 R9 table walk
        for (int k = 0; k < NV; k++) begin
            drive(TBL[k].v, TBL[k].sq, TBL[k].mem, TBL[k].seq);
            chk(pop == TBL[k].pop, $sformatf("R3 R8 pop vec%0d", k), int'(pop), int'(TBL[k].pop));
            chk(entry_rel == TBL[k].rel, $sformatf("R8 rel vec%0d", k), int'(entry_rel), int'(TBL[k].rel));
            chk(active == TBL[k].act, $sformatf("R9 active vec%0d", k), int'(active), int'(TBL[k].act));
            chk(slot_vld == {TBL[k].s1v, TBL[k].s0v}, $sformatf("R2 slot_vld vec%0d", k),
                int'(slot_vld), int'({TBL[k].s1v, TBL[k].s0v}));
            if (TBL[k].s0v) begin
                chk(slot_cls[0] == TBL[k].s0c, $sformatf("R1 slot0 cls vec%0d", k),
                    int'(slot_cls[0]), int'(TBL[k].s0c));
                chk(slot_seq[0] == TBL[k].seq[TBL[k].s0c*8 +: 8], $sformatf("R1 slot0 seq vec%0d", k),
                    int'(slot_seq[0]), int'(TBL[k].seq[TBL[k].s0c*8 +: 8]));
            end
            if (TBL[k].s1v) begin
                chk(slot_cls[1] == TBL[k].s1c, $sformatf("R1 slot1 cls vec%0d", k),
                    int'(slot_cls[1]), int'(TBL[k].s1c));
            end
        end

        // R5: no-unit class ignores long latencies
        op_lat[0] = 3'd3; iss_lat[0] = 3'd3;
        for (int k = 0; k < 2; k++) begin
            drive(4'b0001, 4'b0000, 4'b0000, 32'h00000003);
            chk(slot_vld[0] && slot_cls[0] == 2'd0, "R5 class0 issue", int'(slot_vld), 1);
            chk(slot_late[0] == 1'b0, "R5 class0 not late", int'(slot_late[0]), 0);
        end

        // R6: op latency 3 with issue latency 1 stays immediate
        op_lat[1] = 3'd3; iss_lat[1] = 3'd1;
        for (int k = 0; k < 2; k++) begin
            drive(4'b0010, 4'b0000, 4'b0000, 32'h00000400);
            chk(slot_vld[0] && !slot_late[0], "R6 class1 immediate", int'(slot_late[0]), 0);
        end

        // R7 / R4: class 2 reserved for iss_lat-1 = 2 cycles
        op_lat[2] = 3'd2; iss_lat[2] = 3'd3;
        drive(4'b0100, 4'b0000, 4'b0000, 32'h00320000);          // cycle A, seq 50
        chk(slot_vld[0] && slot_cls[0] == 2'd2 && slot_late[0], "R7 late issue", int'(slot_late[0]), 1);
        chk(pop[2] && entry_rel[2], "R8 late issue releases", int'(entry_rel), 4);
        drive(4'b0100, 4'b0000, 4'b0000, 32'h00330000);          // cycle B, seq 51
        chk(slot_vld == '0 && pop == '0, "R4 busy not granted", int'(pop), 0);
        chk(done_vld[2] == 1'b0, "R7 no early done", int'(done_vld[2]), 0);
        drive(4'b0100, 4'b0000, 4'b0000, 32'h00330000);          // cycle C
        chk(done_vld[2] == 1'b1, "R7 done at iss_lat-1", int'(done_vld[2]), 1);
        chk(done_seq[2] == 8'd50, "R7 done seq", int'(done_seq[2]), 50);
        chk(slot_vld == '0, "R7 still reserved", int'(slot_vld), 0);
        drive(4'b0100, 4'b0000, 4'b0000, 32'h00330000);          // cycle D
        chk(busy_cnt[2] == 8'd2, "R4 busy count", int'(busy_cnt[2]), 2);
        chk(slot_vld[0] && slot_cls[0] == 2'd2 && slot_late[0], "R7 reissue after free", int'(slot_vld), 1);
        drive(4'b0111, 4'b0000, 4'b0000, 32'h00090201);          // cycle E: c2 outside window
        chk(slot_cls[0] == 2'd0 && slot_cls[1] == 2'd1 && slot_vld == 2'b11, "R2 width cut", int'(slot_vld), 3);
        drive(4'b0111, 4'b0000, 4'b0000, 32'h00000201);          // cycle F: c2 oldest but busy
        chk(slot_cls[0] == 2'd0 && slot_cls[1] == 2'd1 && slot_vld == 2'b11, "R4 busy uses no slot", int'(slot_vld), 3);
        chk(done_vld[2] && done_seq[2] == 8'd51, "R7 second done", int'(done_seq[2]), 51);
        drive(4'b0000, 4'b0000, 4'b0000, 32'h0);
        chk(busy_cnt[2] == 8'd3, "R4 counted only when visited", int'(busy_cnt[2]), 3);
        chk(!active, "R9 idle", int'(active), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule